// File: doc/BRIEF.md
# External Bus Strobe Generator

This block shapes the two timing strobes of an 8051-style multiplexed external bus: the address latch enable (ALE, active high) and the program store enable (PSEN, active low). It runs on the oscillator clock and divides it into machine cycles of twelve clocks. Each machine cycle holds six states of two clocks each. A tick count from 0 to 11 marks where the bus is within the current machine cycle, and the block drives that count as an output.

The instruction sequencer supplies four qualifiers:
- execution from external program memory,
- a marker that the coming machine cycle carries an external data memory transfer,
- a marker that the coming cycle belongs to a table-read instruction,
- the ALE-suppress control bit.

The block registers these once per machine cycle. From them it decides which strobe pulses appear, which are omitted, and whether ALE is released to a weak pull-up. Address and data multiplexing on the ports, and instruction decode, belong to neighbouring blocks.

Top module: `bus_strobe_gen`

## Requirements
- R1: `mc_tick` counts 0,1,...,11 and wraps to 0, one step per clock. Tick 0 is the first clock of a machine cycle.
- R2: With no suppression in effect, `ale` is high at ticks 1, 2, 7 and 8 and low at every other tick. This gives two pulses per machine cycle.
- R3: In a cycle marked as an external data transfer, the ALE pulse at ticks 1–2 is omitted and the pulse at ticks 7–8 remains.
- R4: While executing from external program memory, `psen_n` is low at ticks 3, 4, 5 and at ticks 9, 10, 11. This gives two activations per cycle. A table-read marker does not change this.
- R5: In a cycle marked as an external data transfer, both PSEN activations are omitted and `psen_n` stays high for the whole cycle.
- R6: While executing from internal program memory, `psen_n` stays high.
- R7: When the ALE-suppress bit is set and the cycle is internal execution with neither data-transfer nor table-read marker, `ale` stays low and `ale_release` is high for the whole cycle. `ale_release` means the pin is left to its weak pull-up.
- R8: When the ALE-suppress bit is set, a cycle marked as external data transfer or table read produces ALE exactly as R2/R3 prescribe, with `ale_release` low.
- R9: The ALE-suppress bit has no effect while executing from external program memory: ALE follows R2/R3 and `ale_release` stays low.
- R10: The qualifiers are sampled only at the clock edge that ends tick 11. A change during ticks 0–10 does not alter the strobes of the cycle in progress.
- R11: While `rst` is high, `mc_tick` is 0, `ale` is 0, `psen_n` is 1 and `ale_release` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_exec | input | 1 | Code is fetched from external program memory |
| xdata_cyc | input | 1 | Coming machine cycle carries an external data transfer |
| tblrd_cyc | input | 1 | Coming machine cycle belongs to a table-read instruction |
| ale_off | input | 1 | ALE-suppress control bit |
| ale | output | 1 | Address latch enable, active high |
| ale_release | output | 1 | ALE pin released to weak pull-up |
| psen_n | output | 1 | Program store enable, active low |
| mc_tick | output | 4 | Clock position within the machine cycle, 0 to 11 |

## Verification
The hardest case to reach is a qualifier change inside a machine cycle. A broken design would let it leak into that cycle's strobes, even though it belongs to the next cycle. To provoke this, the stimulus waits for tick 5 and inverts every qualifier. It holds them inverted until the tick-11 boundary, then loads the next cycle's settings. The expected strobes for the disturbed cycle are still those of the settings applied at the boundary. The scoreboard also counts ALE and PSEN pulses per cycle in every mode, which catches slots that are omitted or duplicated.

// File: rtl/bstrb_pkg.sv
package bstrb_pkg;

    parameter int STATE_CLKS     = 2;
    parameter int STATES_PER_CYC = 6;
    localparam int CYC_CLKS      = STATE_CLKS * STATES_PER_CYC;
    localparam int TICK_W        = $clog2(CYC_CLKS);

    // two strobe slots per machine cycle, spaced half a cycle apart
    localparam int SLOTS      = 2;
    localparam int SLOT_SPAN  = CYC_CLKS / SLOTS;
    localparam int ALE_OFS    = 1;
    localparam int ALE_W      = STATE_CLKS;
    localparam int PSEN_OFS   = 3;
    localparam int PSEN_W     = STATE_CLKS + 1;
    // ALE slot dropped during an external data transfer cycle
    localparam int XDATA_ALE_SKIP = 0;

    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        logic ext_exec;
        logic xdata;
        logic tblrd;
        logic ale_off;
    } cyc_ctx_t;

    localparam cyc_ctx_t CTX_RESET = '{ext_exec: 1'b0, xdata: 1'b0, tblrd: 1'b0, ale_off: 1'b0};

    function automatic int ale_start(input int slot);
        return ALE_OFS + slot * SLOT_SPAN;
    endfunction

    function automatic int psen_start(input int slot);
        return PSEN_OFS + slot * SLOT_SPAN;
    endfunction

    function automatic logic in_window(input tick_t t, input int start, input int width);
        return (int'(t) >= start) && (int'(t) < start + width);
    endfunction

    // ALE may pulse in this cycle (otherwise the pin is released)
    function automatic logic ale_allowed(input cyc_ctx_t c);
        return c.ext_exec | ~c.ale_off | c.xdata | c.tblrd;
    endfunction

endpackage

// File: rtl/bstrb_phase_ctr.sv
module bstrb_phase_ctr
    import bstrb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output tick_t tick_q,
    output tick_t tick_nx,
    output logic  wrap_nx
);

    always_comb begin
        wrap_nx = (tick_q == tick_t'(CYC_CLKS - 1));
        tick_nx = wrap_nx ? '0 : tick_t'(tick_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= '0;
        else     tick_q <= tick_nx;
    end

endmodule

// File: rtl/bstrb_ctx_reg.sv
module bstrb_ctx_reg
    import bstrb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wrap_nx,
    input  cyc_ctx_t ctx_in,
    output cyc_ctx_t ctx_q,
    output cyc_ctx_t ctx_nx
);

    // qualifiers enter only at the machine-cycle boundary
    always_comb ctx_nx = wrap_nx ? ctx_in : ctx_q;

    always_ff @(posedge clk) begin
        if (rst) ctx_q <= CTX_RESET;
        else     ctx_q <= ctx_nx;
    end

endmodule

// File: rtl/bstrb_shaper.sv
module bstrb_shaper
    import bstrb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tick_t    tick_nx,
    input  cyc_ctx_t ctx_nx,
    output logic     ale_q,
    output logic     psen_n_q,
    output logic     rel_q
);

    logic [SLOTS-1:0] ale_keep;
    logic [SLOTS-1:0] psen_hit;
    logic             allow;
    logic             ale_d;
    logic             psen_act;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic ale_hit;
        logic drop;
        assign ale_hit     = in_window(tick_nx, ale_start(s), ALE_W);
        assign drop        = ctx_nx.xdata && (s == XDATA_ALE_SKIP);
        assign ale_keep[s] = ale_hit & ~drop;
        assign psen_hit[s] = in_window(tick_nx, psen_start(s), PSEN_W);
    end

    always_comb begin
        allow    = ale_allowed(ctx_nx);
        ale_d    = allow & (|ale_keep);
        psen_act = ctx_nx.ext_exec & ~ctx_nx.xdata & (|psen_hit);
    end

    // strobes come straight from flops, aligned with the registered tick
    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q    <= 1'b0;
            psen_n_q <= 1'b1;
            rel_q    <= 1'b0;
        end else begin
            ale_q    <= ale_d;
            psen_n_q <= ~psen_act;
            rel_q    <= ~allow;
        end
    end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bstrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_exec,
    input  logic              xdata_cyc,
    input  logic              tblrd_cyc,
    input  logic              ale_off,
    output logic              ale,
    output logic              ale_release,
    output logic              psen_n,
    output logic [TICK_W-1:0] mc_tick
);

    tick_t    tick_q;
    tick_t    tick_nx;
    logic     wrap_nx;
    cyc_ctx_t ctx_in;
    cyc_ctx_t ctx_q;
    cyc_ctx_t ctx_nx;

    assign ctx_in = '{ext_exec: ext_exec, xdata: xdata_cyc, tblrd: tblrd_cyc, ale_off: ale_off};

    bstrb_phase_ctr u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick_q  (tick_q),
        .tick_nx (tick_nx),
        .wrap_nx (wrap_nx)
    );

    bstrb_ctx_reg u_ctx (
        .clk     (clk),
        .rst     (rst),
        .wrap_nx (wrap_nx),
        .ctx_in  (ctx_in),
        .ctx_q   (ctx_q),
        .ctx_nx  (ctx_nx)
    );

    bstrb_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .tick_nx  (tick_nx),
        .ctx_nx   (ctx_nx),
        .ale_q    (ale),
        .psen_n_q (psen_n),
        .rel_q    (ale_release)
    );

    assign mc_tick = tick_q;

endmodule

// File: rtl/bus_strobe_chk.sv
module bus_strobe_chk
    import bstrb_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input tick_t    tick,
    input logic     ale,
    input logic     psen_n,
    input logic     rel,
    input cyc_ctx_t ctx
);

    assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (tick == tick_t'(CYC_CLKS - 1)) |=> (tick == '0));

    assert_tick_step_R1: assert property (@(posedge clk) disable iff (rst)
        (tick != tick_t'(CYC_CLKS - 1)) |=> (tick == tick_t'($past(tick) + 1'b1)));

    assert_xdata_first_ale_gone_R3: assert property (@(posedge clk) disable iff (rst)
        (ctx.xdata && in_window(tick, ale_start(XDATA_ALE_SKIP), ALE_W)) |-> !ale);

    assert_psen_needs_ext_R6: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> ctx.ext_exec);

    assert_psen_quiet_xdata_R5: assert property (@(posedge clk) disable iff (rst)
        ctx.xdata |-> psen_n);

    assert_strobes_disjoint_R4: assert property (@(posedge clk) disable iff (rst)
        !(ale && !psen_n));

    assert_released_low_R7: assert property (@(posedge clk) disable iff (rst)
        rel |-> !ale);

    assert_no_release_ext_R9: assert property (@(posedge clk) disable iff (rst)
        ctx.ext_exec |-> !rel);

    assert_ctx_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tick != tick_t'(CYC_CLKS - 1)) |=> $stable(ctx));

endmodule

bind bus_strobe_gen bus_strobe_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (mc_tick),
    .ale    (ale),
    .psen_n (psen_n),
    .rel    (ale_release),
    .ctx    (ctx_q)
);

// File: tb/bus_strobe_gen_tb_top.sv
module bus_strobe_gen_tb_top;

    typedef struct {
        int    tick;
        bit    ale;
        bit    psen_n;
        bit    rel;
        string tag;
    } item_t;

    typedef struct {
        int    n_ale;
        int    n_psen;
        string tag;
    } cnt_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_exec = 1'b0, xdata_cyc = 1'b0, tblrd_cyc = 1'b0, ale_off = 1'b0;
    logic       ale, ale_release, psen_n;
    logic [3:0] mc_tick;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    item_t exp_q[$];
    cnt_t  cnt_q[$];

    always #10 clk = ~clk;   // 50 MHz

    bus_strobe_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .ext_exec    (ext_exec),
        .xdata_cyc   (xdata_cyc),
        .tblrd_cyc   (tblrd_cyc),
        .ale_off     (ale_off),
        .ale         (ale),
        .ale_release (ale_release),
        .psen_n      (psen_n),
        .mc_tick     (mc_tick)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // driver: sets the qualifiers at the last tick and queues the whole cycle
    task automatic run_cyc(input bit e, input bit x, input bit t, input bit off,
                           input string tag, input bit glitch);
        bit   allow;
        cnt_t c;
        do @(negedge clk); while (mc_tick != 4'd11);
        ext_exec = e; xdata_cyc = x; tblrd_cyc = t; ale_off = off;
        allow = e || !off || x || t;
        for (int k = 0; k < 12; k++) begin
            item_t it;
            it.tick   = k;
            it.ale    = allow && ((((k == 1) || (k == 2)) && !x) || (k == 7) || (k == 8));
            it.psen_n = !(e && !x && (((k >= 3) && (k <= 5)) || (k >= 9)));
            it.rel    = !allow;
            it.tag    = tag;
            exp_q.push_back(it);
        end
        c.n_ale  = allow ? (x ? 1 : 2) : 0;
        c.n_psen = (e && !x) ? 2 : 0;
        c.tag    = tag;
        cnt_q.push_back(c);
        if (glitch) begin
            do @(negedge clk); while (mc_tick != 4'd5);
            ext_exec = !e; xdata_cyc = !x; tblrd_cyc = !t; ale_off = !off;
        end
    endtask

    // monitor: compares every tick and counts pulses per machine cycle
    int ca = 0, cp = 0;
    bit pa = 0, pp = 1;
    always @(posedge clk) begin
        #1;
        if (!rst && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            if (it.tick == 0) begin ca = 0; cp = 0; pa = 0; pp = 1; end
            check(int'(mc_tick) == it.tick, "R1", "mc_tick", int'(mc_tick), it.tick);
            check(ale == it.ale, it.tag, $sformatf("ale@%0d", it.tick), ale, it.ale);
            check(psen_n == it.psen_n, it.tag, $sformatf("psen_n@%0d", it.tick), psen_n, it.psen_n);
            check(ale_release == it.rel, it.tag, $sformatf("ale_release@%0d", it.tick), ale_release, it.rel);
            if (ale && !pa) ca++;
            if (!psen_n && pp) cp++;
            pa = ale; pp = psen_n;
            if (it.tick == 11) begin
                cnt_t c;
                c = cnt_q.pop_front();
                check(ca == c.n_ale, c.tag, "ALE pulses per cycle", ca, c.n_ale);
                check(cp == c.n_psen, c.tag, "PSEN pulses per cycle", cp, c.n_psen);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: state held during reset
        check(mc_tick == 4'd0, "R11", "mc_tick in reset", int'(mc_tick), 0);
        check(ale == 1'b0, "R11", "ale in reset", ale, 0);
        check(psen_n == 1'b1, "R11", "psen_n in reset", psen_n, 1);
        check(ale_release == 1'b0, "R11", "ale_release in reset", ale_release, 0);
        rst = 1'b0;

        run_cyc(0, 0, 0, 0, "R2/R6 normal internal", 0);
        run_cyc(0, 1, 0, 0, "R3 internal xdata", 0);
        run_cyc(0, 1, 0, 0, "R3 back-to-back xdata", 0);
        run_cyc(1, 0, 0, 0, "R4 external exec", 0);
        run_cyc(1, 0, 1, 0, "R4 external tblrd", 0);
        run_cyc(1, 1, 0, 0, "R5 external xdata", 0);
        run_cyc(1, 0, 0, 0, "R4 after xdata", 0);
        run_cyc(0, 0, 1, 0, "R6 internal tblrd", 0);
        run_cyc(0, 0, 0, 1, "R7 ale suppressed", 0);
        run_cyc(0, 0, 1, 1, "R8 suppressed tblrd", 0);
        run_cyc(0, 1, 0, 1, "R8 suppressed xdata", 0);
        run_cyc(1, 0, 0, 1, "R9 suppress in external", 0);
        run_cyc(1, 1, 0, 1, "R9 suppress external xdata", 0);
        run_cyc(0, 0, 0, 0, "R10 glitch normal", 1);
        run_cyc(0, 0, 0, 1, "R10 glitch suppressed", 1);
        run_cyc(1, 1, 0, 0, "R10 glitch ext xdata", 1);
        run_cyc(1, 0, 0, 0, "R10 glitch ext", 1);
        run_cyc(0, 0, 0, 0, "R2 final", 0);

        repeat (14) @(posedge clk);
        #2;
        check(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);
        finish_up();
    end

endmodule